// File: doc/BRIEF.md
# Tapped-Delay Multi-Phase Cycle Timer

This block is a clocked model of a processor's central timing generator. One clock period stands for 15 ns. A start gate launches a cycle pulse that is `PULSE_TICKS` clocks wide into an 11-stage shift register. Taps on that register sit 15, 30, 45, 60, 75, 90 and 150 ns from the launch. A phase output follows its tap: it goes active when the leading edge of the pulse reaches the tap and inactive when the trailing edge reaches it. Three set/clear latches build wider strobes from tap edges. These are a register-transfer strobe pair in true and complement form, an active-low sequence strobe and a file-store strobe.

The start gate needs three things: the run enable, an armed start latch and an open end-of-cycle gate. Every launch disarms the start latch. The rising edge at the 60 ns tap also disarms it, and the rising edge at the 90 ns tap re-arms it. The end-of-cycle gate closes on the rising edge at the 45 ns tap and reopens on the falling edge there. While run enable stays high, the timer therefore relaunches as soon as both conditions allow, and it runs freely.

Timing convention: call L the clock cycle in which `run_en` is high, `rst` is low and the timer is ready. All outputs are registered. "Active in cycle L+k" means the value after the clock edge that ends cycle L+k-1. W stands for `PULSE_TICKS`.

Top module: `cyc_timer`

## Requirements
- R1: While `rst` is high, and from then on until the first launch, every strobe is inactive: active-high outputs are 0, and `xset_n`, `late_n`, `xfer_stb_n` and `seq_stb_n` are 1.
- R2: In a launch cycle L, `ucode_stb` (the 15 ns phase) is high for cycles L+1 through L+W.
- R3: `rd_stb` is high for L+2 to L+W+1. `c60_stb` is high for L+4 to L+W+3. `dout_stb` is high for L+5 to L+W+4. `late_n` is low for L+10 to L+W+9.
- R4: `xset_n` is low only while `ucode_stb` and `rd_stb` are both high, which is L+2 to L+W.
- R5: `xfer_stb` is set by the falling edge of the 15 ns phase and cleared by the falling edge of the 60 ns phase. It is high for L+W+2 to L+W+4, and `xfer_stb_n` is always its complement.
- R6: `seq_stb_n` goes low at L+W+3, one cycle after the 30 ns phase falls. It stays low up to and including the next launch cycle, and it goes high in the cycle after that launch.
- R7: `fstore_stb` is set by the falling edge of the 45 ns phase and cleared by the falling edge of the 75 ns phase. It is high for L+W+4 to L+W+5.
- R8: No launch occurs before cycle L+max(7, W+4). With `run_en` held high, launches repeat with exactly that period.
- R9: When `run_en` goes low, a cycle already launched runs to completion on every output, and no further cycle starts.
- R10: A synchronous reset in the middle of a cycle clears all phases and latches from the next cycle on. The timer then stays idle until `run_en` launches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per 15 ns tick |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; launches cycles while high |
| ucode_stb | output | 1 | 15 ns phase, microcode-latch strobe |
| rd_stb | output | 1 | 30 ns phase, read strobe |
| xset_n | output | 1 | Active-low set pulse, overlap of 15 and 30 ns phases |
| c60_stb | output | 1 | 60 ns phase |
| dout_stb | output | 1 | 75 ns phase, data-out strobe |
| late_n | output | 1 | Active-low 150 ns late strobe |
| xfer_stb | output | 1 | Register-transfer strobe, true form |
| xfer_stb_n | output | 1 | Register-transfer strobe, complement form |
| seq_stb_n | output | 1 | Active-low sequence-register strobe |
| fstore_stb | output | 1 | File-store strobe |

## Verification
With the default width of 4, a free-running timer relaunches in cycle L+8. That is the last cycle of the previous data-out strobe. The same launch also clears the previous sequence strobe, while the late strobe of the previous cycle has not yet arrived. Holding `run_en` high produces this overlap. A scoreboard judges it: the expected output in each cycle is the union of the windows of every launch so far, so a shared register or a cleared tail in the design shows up as a mismatch on a single output in a single cycle.

// File: rtl/cyc_timer_pkg.sv
`timescale 1ns/1ps
package cyc_timer_pkg;

    localparam int TICK_NS  = 15;
    localparam int NUM_TAPS = 7;

    // tap indices, ordered by delay
    localparam int TP_15  = 0;
    localparam int TP_30  = 1;
    localparam int TP_45  = 2;
    localparam int TP_60  = 3;
    localparam int TP_75  = 4;
    localparam int TP_90  = 5;
    localparam int TP_150 = 6;

    function automatic int tap_delay_ns(input int idx);
        case (idx)
            TP_15:   return 15;
            TP_30:   return 30;
            TP_45:   return 45;
            TP_60:   return 60;
            TP_75:   return 75;
            TP_90:   return 90;
            default: return 150;
        endcase
    endfunction

    // stage 0 carries the pulse one tick after launch
    function automatic int tap_stage(input int idx);
        return tap_delay_ns(idx) / TICK_NS - 1;
    endfunction

    localparam int LAST_STAGE = tap_stage(NUM_TAPS - 1);
    // one stage past the deepest tap so its edges are visible
    localparam int LINE_DEPTH = LAST_STAGE + 2;

    // latched strobes
    localparam int LT_XFER  = 0;
    localparam int LT_SEQ   = 1;
    localparam int LT_STORE = 2;
    localparam int NUM_LATCH = 3;

    function automatic logic lvl_at(input logic [LINE_DEPTH-1:0] v, input int idx);
        return v[tap_stage(idx)];
    endfunction

    function automatic logic rise_at(input logic [LINE_DEPTH-1:0] v, input int idx);
        return v[tap_stage(idx)] & ~v[tap_stage(idx) + 1];
    endfunction

    function automatic logic fall_at(input logic [LINE_DEPTH-1:0] v, input int idx);
        return ~v[tap_stage(idx)] & v[tap_stage(idx) + 1];
    endfunction

    typedef struct packed {
        logic ucode;
        logic rd;
        logic xset_n;
        logic c60;
        logic dout;
        logic late_n;
        logic xfer;
        logic xfer_n;
        logic seq_n;
        logic fstore;
    } phase_bus_t;

endpackage

// File: rtl/cyc_timer_line.sv
`timescale 1ns/1ps
module cyc_timer_line #(
    parameter int DEPTH = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src,
    output logic [DEPTH-1:0] stages
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            stages <= {stages[DEPTH-2:0], src};
        end
    end

endmodule

// File: rtl/cyc_timer_launch.sv
`timescale 1ns/1ps
module cyc_timer_launch #(
    parameter int PULSE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic arm_block,
    input  logic arm_release,
    input  logic eoc_close,
    input  logic eoc_reopen,
    output logic launch,
    output logic src
);

    localparam int CW = $clog2(PULSE_TICKS + 1);

    logic [CW-1:0] hold_cnt;
    logic          armed;
    logic          eoc_open;

    assign launch = ~rst & run_en & armed & eoc_open & (hold_cnt == '0);
    assign src    = launch | (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            armed    <= 1'b1;
            eoc_open <= 1'b1;
        end else begin
            if (launch) begin
                hold_cnt <= CW'(PULSE_TICKS - 1);
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - CW'(1);
            end

            if (launch || arm_block) begin
                armed <= 1'b0;
            end else if (arm_release) begin
                armed <= 1'b1;
            end

            if (eoc_close) begin
                eoc_open <= 1'b0;
            end else if (eoc_reopen) begin
                eoc_open <= 1'b1;
            end
        end
    end

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);  // R8

    AST_SRC_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $rose(src) |-> launch);  // R2

endmodule

// File: rtl/cyc_timer_latch.sv
`timescale 1ns/1ps
module cyc_timer_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set_ev) begin
            q <= 1'b1;
        end else if (clr_ev) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer
    import cyc_timer_pkg::*;
#(
    parameter int PULSE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic ucode_stb,
    output logic rd_stb,
    output logic xset_n,
    output logic c60_stb,
    output logic dout_stb,
    output logic late_n,
    output logic xfer_stb,
    output logic xfer_stb_n,
    output logic seq_stb_n,
    output logic fstore_stb
);

    generate
        if (PULSE_TICKS < 1 || PULSE_TICKS > 16) begin : g_bad_width
            $error("cyc_timer: PULSE_TICKS must lie in 1..16");
        end
    endgenerate

    logic                  launch;
    logic                  src;
    logic [LINE_DEPTH-1:0] line;
    logic [NUM_LATCH-1:0]  lat_set;
    logic [NUM_LATCH-1:0]  lat_clr;
    logic [NUM_LATCH-1:0]  lat_q;
    phase_bus_t            bus;

    cyc_timer_launch #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_launch (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .arm_block   (rise_at(line, TP_60)),
        .arm_release (rise_at(line, TP_90)),
        .eoc_close   (rise_at(line, TP_45)),
        .eoc_reopen  (fall_at(line, TP_45)),
        .launch      (launch),
        .src         (src)
    );

    cyc_timer_line #(
        .DEPTH (LINE_DEPTH)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .stages (line)
    );

    // latch event routing
    always_comb begin
        lat_set[LT_XFER]  = fall_at(line, TP_15);
        lat_clr[LT_XFER]  = fall_at(line, TP_60);
        lat_set[LT_SEQ]   = fall_at(line, TP_30);
        lat_clr[LT_SEQ]   = launch;
        lat_set[LT_STORE] = fall_at(line, TP_45);
        lat_clr[LT_STORE] = fall_at(line, TP_75);
    end

    generate
        for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
            cyc_timer_latch u_lat (
                .clk    (clk),
                .rst    (rst),
                .set_ev (lat_set[i]),
                .clr_ev (lat_clr[i]),
                .q      (lat_q[i])
            );
        end
    endgenerate

    always_comb begin
        bus.ucode  = lvl_at(line, TP_15);
        bus.rd     = lvl_at(line, TP_30);
        bus.xset_n = ~(lvl_at(line, TP_15) & lvl_at(line, TP_30));
        bus.c60    = lvl_at(line, TP_60);
        bus.dout   = lvl_at(line, TP_75);
        bus.late_n = ~lvl_at(line, TP_150);
        bus.xfer   = lat_q[LT_XFER];
        bus.xfer_n = ~lat_q[LT_XFER];
        bus.seq_n  = ~lat_q[LT_SEQ];
        bus.fstore = lat_q[LT_STORE];
    end

    assign ucode_stb  = bus.ucode;
    assign rd_stb     = bus.rd;
    assign xset_n     = bus.xset_n;
    assign c60_stb    = bus.c60;
    assign dout_stb   = bus.dout;
    assign late_n     = bus.late_n;
    assign xfer_stb   = bus.xfer;
    assign xfer_stb_n = bus.xfer_n;
    assign seq_stb_n  = bus.seq_n;
    assign fstore_stb = bus.fstore;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!ucode_stb && !xfer_stb && seq_stb_n && !fstore_stb && late_n));  // R1

    AST_LAUNCH_CLEAR_OF_T45: assert property (@(posedge clk) disable iff (rst)
        launch |-> !lvl_at(line, TP_45));  // R8

    AST_XFER_FROM_T15: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_stb) |-> ($past(ucode_stb, 2) && !$past(ucode_stb)));  // R5

    AST_XFER_CLR_T60: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_stb) |-> ($past(c60_stb, 2) && !$past(c60_stb)));  // R5

    AST_SEQ_FROM_T30: assert property (@(posedge clk) disable iff (rst)
        $fell(seq_stb_n) |-> ($past(rd_stb, 2) && !$past(rd_stb)));  // R6

    AST_STORE_INSIDE_XFER: assert property (@(posedge clk) disable iff (rst)
        $rose(fstore_stb) |-> xfer_stb);  // R7

    AST_STORE_CLR_T75: assert property (@(posedge clk) disable iff (rst)
        $fell(fstore_stb) |-> ($past(dout_stb, 2) && !$past(dout_stb)));  // R7

endmodule

// File: tb/cyc_timer_test.sv
`timescale 1ns/1ps
module cyc_timer_test;

    localparam int W    = 4;
    localparam int GAP  = (W + 4 > 7) ? W + 4 : 7;
    localparam int LAST = 175;
    localparam int FAR  = 1 << 30;

    logic clk    = 1'b0;
    logic rst    = 1'b1;
    logic run_en = 1'b0;
    logic ucode_stb, rd_stb, xset_n, c60_stb, dout_stb, late_n;
    logic xfer_stb, xfer_stb_n, seq_stb_n, fstore_stb;

    typedef struct packed {
        logic ucode, rd, xset_n, c60, dout, late_n, xfer, xfer_n, seq_n, fstore;
    } view_t;

    view_t expq[$];
    string ctxq[$];
    int    launches[$];
    int    next_ok  = 0;
    int    n_launch = 0;
    int    total    = 0;
    int    bad      = 0;
    int    rises    = 0;
    int    mon_k    = 0;
    logic  prev_ucode = 1'b0;
    bit    done     = 1'b0;
    view_t cur_e;
    string cur_c;

    always #2.5 clk = ~clk;

    cyc_timer #(.PULSE_TICKS(W)) uut (
        .clk(clk), .rst(rst), .run_en(run_en),
        .ucode_stb(ucode_stb), .rd_stb(rd_stb), .xset_n(xset_n),
        .c60_stb(c60_stb), .dout_stb(dout_stb), .late_n(late_n),
        .xfer_stb(xfer_stb), .xfer_stb_n(xfer_stb_n),
        .seq_stb_n(seq_stb_n), .fstore_stb(fstore_stb)
    );

    task automatic chk(input string nm, input string req, input string ctx,
                       input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s [%s] cycle %0d: got %b expected %b",
                     req, nm, ctx, mon_k, got, exp);
        end
    endtask

    function automatic bit win(input int t, input int lo, input int hi);
        return (t >= lo) && (t <= hi);
    endfunction

    // expected outputs in cycle t from all launches recorded so far
    function automatic view_t model(input int t);
        view_t e;
        e = '{ucode:1'b0, rd:1'b0, xset_n:1'b1, c60:1'b0, dout:1'b0, late_n:1'b1,
              xfer:1'b0, xfer_n:1'b1, seq_n:1'b1, fstore:1'b0};
        for (int i = 0; i < launches.size(); i++) begin
            int lc = launches[i];
            int nx = (i + 1 < launches.size()) ? launches[i+1] : FAR;
            if (win(t, lc+1,  lc+W))   e.ucode  = 1'b1;
            if (win(t, lc+2,  lc+W+1)) e.rd     = 1'b1;
            if (win(t, lc+2,  lc+W))   e.xset_n = 1'b0;
            if (win(t, lc+4,  lc+W+3)) e.c60    = 1'b1;
            if (win(t, lc+5,  lc+W+4)) e.dout   = 1'b1;
            if (win(t, lc+10, lc+W+9)) e.late_n = 1'b0;
            if (win(t, lc+W+2, lc+W+4)) begin e.xfer = 1'b1; e.xfer_n = 1'b0; end
            if (win(t, lc+W+3, nx))    e.seq_n  = 1'b0;
            if (win(t, lc+W+4, lc+W+5)) e.fstore = 1'b1;
        end
        return e;
    endfunction

    task automatic sched(input int k, output logic r, output logic e, output string c);
        r = 1'b0; e = 1'b0; c = "R9 drain";
        if (k < 4)                     begin r = 1'b1; c = "R1 reset"; end
        else if (k < 12)               c = "R1 idle";
        else if (k == 12)              begin e = 1'b1; c = "R2 single launch"; end
        else if (k < 30)               c = "R9 drain after single";
        else if (k < 80)               begin e = 1'b1; c = "R8 free-run overlap"; end
        else if (k < 100)              c = "R9 stop mid-cycle";
        else if (k < 104)              begin e = 1'b1; c = "R2 relaunch"; end
        else if (k == 104)             c = "R10 pre-reset";
        else if (k < 107)              begin r = 1'b1; c = "R10 reset mid-cycle"; end
        else if (k < 113)              c = "R10 idle after reset";
        else if (k < 125)              begin e = 1'b1; c = "R8 second run"; end
        else if (k == 140)             begin e = 1'b1; c = "R2 isolated launch"; end
        else if (k == 143)             begin e = 1'b1; c = "R8 blocked request"; end
        else if (k >= 146 && k < 150)  begin e = 1'b1; c = "R8 earliest relaunch"; end
    endtask

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            cur_e = expq.pop_front();
            cur_c = ctxq.pop_front();
            chk("ucode_stb",  "R2", cur_c, ucode_stb,  cur_e.ucode);
            chk("rd_stb",     "R3", cur_c, rd_stb,     cur_e.rd);
            chk("xset_n",     "R4", cur_c, xset_n,     cur_e.xset_n);
            chk("c60_stb",    "R3", cur_c, c60_stb,    cur_e.c60);
            chk("dout_stb",   "R3", cur_c, dout_stb,   cur_e.dout);
            chk("late_n",     "R3", cur_c, late_n,     cur_e.late_n);
            chk("xfer_stb",   "R5", cur_c, xfer_stb,   cur_e.xfer);
            chk("xfer_stb_n", "R5", cur_c, xfer_stb_n, cur_e.xfer_n);
            chk("seq_stb_n",  "R6", cur_c, seq_stb_n,  cur_e.seq_n);
            chk("fstore_stb", "R7", cur_c, fstore_stb, cur_e.fstore);
        end
        if (ucode_stb === 1'b1 && prev_ucode === 1'b0) rises++;
        prev_ucode = ucode_stb;
        mon_k++;
    end

    // driver: applies stimulus and pushes the expected view of the next cycle
    initial begin
        logic  r, e;
        string c;
        for (int k = 0; k <= LAST; k++) begin
            @(negedge clk);
            #1;
            sched(k, r, e, c);
            rst    = r;
            run_en = e;
            if (r) begin
                launches.delete();
                next_ok = 0;
            end else if (e && k >= next_ok) begin
                launches.push_back(k);
                next_ok = k + GAP;
                n_launch++;
            end
            expq.push_back(model(k + 1));
            ctxq.push_back(c);
        end
        @(negedge clk);
        #1;
        total++;
        if (rises != n_launch) begin
            bad++;
            $display("FAIL R8 launch count: got %0d expected %0d", rises, n_launch);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule